// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Register

This block is the arithmetic core of a small load/store processor. It takes two byte-wide operands and a two-bit operation code that selects addition, subtraction, increment or decrement. The result is combinational and appears in the same cycle. Increment and decrement act on the first operand alone and ignore the second.

Alongside the result, the block keeps an eight-bit status register. When an operation is marked valid, the register captures carry, half-carry, zero, negative, overflow and sign for that operation. Each operation owns a mask that says which flags it may change. Two further bits, interrupt-enable and transfer, are never touched by arithmetic. Software can overwrite the whole status byte through a write port, and that write takes precedence over any flag update in the same cycle.

Top module: `arith_status_unit`

## Requirements
- R1: With opSel=0 (add), result equals (opA + opB) modulo 256.
- R2: With opSel=1 (subtract), result equals (opA - opB) modulo 256.
- R3: With opSel=2 (increment) result equals opA + 1 modulo 256. With opSel=3 (decrement) result equals opA - 1 modulo 256. opB has no effect in either case.
- R4: Status bit 0 (C). After a valid add it is set when the sum exceeds 255. After a valid subtract it is set when opB is greater than opA (a borrow).
- R5: Status bit 5 (H). After a valid add it is set on a carry out of the low nibble. After a valid subtract it is set when the low nibble of opB exceeds the low nibble of opA.
- R6: Status bit 1 (Z). After any valid operation it is set exactly when the 8-bit result is zero.
- R7: Status bit 2 (N) equals result bit 7. Status bit 3 (V) flags signed overflow. Increment sets V only for 0x7F, and decrement sets V only for 0x80.
- R8: Status bit 4 (S) equals N XOR V after any valid operation.
- R9: Increment and decrement leave C (bit 0) and H (bit 5) at their previous values.
- R10: Arithmetic never changes bit 7 (I) or bit 6 (T).
- R11: When statWrEn is high, the status register loads statWrData on the next edge. This holds even when a valid operation is presented in the same cycle.
- R12: With opValid and statWrEn both low, the status register holds its value.
- R13: While rstN is low, the status register clears to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Applies the flags of the current operation on the next edge |
| opSel | input | 2 | 0 add, 1 subtract, 2 increment, 3 decrement |
| opA | input | 8 | First operand (minuend; the operand for increment and decrement) |
| opB | input | 8 | Second operand |
| statWrEn | input | 1 | Whole-byte status write enable |
| statWrData | input | 8 | Status byte to load |
| result | output | 8 | Combinational result |
| statusOut | output | 8 | Status register: I,T,H,S,V,N,Z,C from bit 7 down to bit 0 |

## Verification
The hardest case to reach from the ports is proving that increment and decrement preserve C and H, and that no operation disturbs I and T. A register that happens to hold zero in those bits hides a wrongful clear. So before every operation the bench loads a status byte through the write port, using a seed that changes with the operands and the operation code. Each preserved bit is therefore seen at both values across the sweep. The sweep covers every first operand against a spread of second operands that includes the nibble and sign boundaries. The flag examples 0x9C+0x64, 0x38+0x2F, 0x52-0x73 and 0xA5-0x23 are also checked directly, as is a status write that coincides with a valid operation.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_INC = 2'd2,
    OP_DEC = 2'd3
  } asuOp_e;

  // status byte bit positions
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_V = 3;
  localparam int BIT_S = 4;
  localparam int BIT_H = 5;
  localparam int BIT_T = 6;
  localparam int BIT_I = 7;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic subMode;     // subtract path
    logic unitOperand; // second operand forced to one
    logic updCarry;    // write C
    logic updHalf;     // write H
    logic updArith;    // write Z, N, V, S
    logic loadAll;     // whole-byte load
  } asuStrobe_t;

endpackage

// File: rtl/asu_ctrl.sv
module asu_ctrl
  import asu_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opSel,
  input  logic       statWrEn,
  output asuStrobe_t strobe
);

  asuOp_e opKind;
  logic   applyOp;

  assign opKind  = asuOp_e'(opSel);
  assign applyOp = opValid && !statWrEn;

  always_comb begin
    strobe          = '0;
    strobe.loadAll  = statWrEn;
    strobe.updArith = applyOp;
    unique case (opKind)
      OP_ADD: begin
        strobe.updCarry = applyOp;
        strobe.updHalf  = applyOp;
      end
      OP_SUB: begin
        strobe.subMode  = 1'b1;
        strobe.updCarry = applyOp;
        strobe.updHalf  = applyOp;
      end
      OP_INC: begin
        strobe.unitOperand = 1'b1;
      end
      OP_DEC: begin
        strobe.subMode     = 1'b1;
        strobe.unitOperand = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/asu_datapath.sv
module asu_datapath
  import asu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  asuStrobe_t          strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [STAT_W-1:0]   wrData,
  output logic [DATA_W-1:0]   result,
  output logic [STAT_W-1:0]   status
);

  localparam int NIB_W  = 4;
  localparam int MSB    = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] rhs;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    nib;
  logic              carryOut, halfOut, zeroOut, negOut, ovfOut;

  assign rhs = strobe.unitOperand ? ONE : opB;

  always_comb begin
    if (strobe.subMode) begin
      wide = {1'b0, opA} - {1'b0, rhs};
      nib  = {1'b0, opA[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]};
    end else begin
      wide = {1'b0, opA} + {1'b0, rhs};
      nib  = {1'b0, opA[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]};
    end
  end

  assign result   = wide[DATA_W-1:0];
  assign carryOut = wide[DATA_W];
  assign halfOut  = nib[NIB_W];
  assign zeroOut  = (result == '0);
  assign negOut   = result[MSB];
  assign ovfOut   = strobe.subMode
                  ? ((opA[MSB] != rhs[MSB]) && (result[MSB] != opA[MSB]))
                  : ((opA[MSB] == rhs[MSB]) && (result[MSB] != opA[MSB]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
    end else if (strobe.loadAll) begin
      status <= wrData;
    end else begin
      if (strobe.updCarry) status[BIT_C] <= carryOut;
      if (strobe.updHalf)  status[BIT_H] <= halfOut;
      if (strobe.updArith) begin
        status[BIT_Z] <= zeroOut;
        status[BIT_N] <= negOut;
        status[BIT_V] <= ovfOut;
        status[BIT_S] <= negOut ^ ovfOut;
      end
    end
  end

endmodule

// File: rtl/arith_status_unit.sv
module arith_status_unit
  import asu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              statWrEn,
  input  logic [STAT_W-1:0] statWrData,
  output logic [DATA_W-1:0] result,
  output logic [STAT_W-1:0] statusOut
);

  asuStrobe_t strobe;

  asu_ctrl ctrl_i (
    .opValid  (opValid),
    .opSel    (opSel),
    .statWrEn (statWrEn),
    .strobe   (strobe)
  );

  asu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .wrData (statWrData),
    .result (result),
    .status (statusOut)
  );

endmodule

// File: rtl/asu_checker.sv
module asu_checker
  import asu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              statWrEn,
  input logic [STAT_W-1:0] statWrData,
  input logic [DATA_W-1:0] result,
  input logic [STAT_W-1:0] statusOut
);

  logic doOp;
  assign doOp = opValid && !statWrEn;

  a_r11_whole_write: assert property (@(posedge clk) disable iff (!rstN)
    statWrEn |=> statusOut == $past(statWrData));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !statWrEn) |=> $stable(statusOut));

  a_r9_incdec_keep: assert property (@(posedge clk) disable iff (!rstN)
    (doOp && opSel[1]) |=> (statusOut[BIT_C] == $past(statusOut[BIT_C]))
                        && (statusOut[BIT_H] == $past(statusOut[BIT_H])));

  a_r10_it_keep: assert property (@(posedge clk) disable iff (!rstN)
    doOp |=> statusOut[BIT_I:BIT_T] == $past(statusOut[BIT_I:BIT_T]));

  a_r8_sign_rule: assert property (@(posedge clk) disable iff (!rstN)
    doOp |=> statusOut[BIT_S] == (statusOut[BIT_N] ^ statusOut[BIT_V]));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    doOp |=> statusOut[BIT_Z] == ($past(result) == '0));

  a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    doOp |=> statusOut[BIT_N] == $past(result[DATA_W-1]));

  a_r3_inc_result: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'd2) |-> result == DATA_W'(opA + DATA_W'(1)));

  a_r13_reset_clear: assert property (@(posedge clk)
    !rstN |=> statusOut == '0);

  logic unusedB;
  assign unusedB = ^opB;

endmodule

bind arith_status_unit asu_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/arith_status_unit_tb_top.sv
`timescale 1ns/1ps
module arith_status_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [1:0] opSel;
  logic [7:0] opA, opB;
  logic       statWrEn;
  logic [7:0] statWrData;
  logic [7:0] result;
  logic [7:0] statusOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  arith_status_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .statWrEn(statWrEn), .statWrData(statWrData),
    .result(result), .statusOut(statusOut)
  );

  function automatic logic [7:0] expRes(input int op, input int a, input int b);
    int r;
    case (op)
      0: r = a + b;
      1: r = a - b + 256;
      2: r = a + 1;
      default: r = a + 255;
    endcase
    return 8'(r % 256);
  endfunction

  // flags per requirements: C0 Z1 N2 V3 S4 H5 T6 I7
  function automatic logic [7:0] expStat(input int op, input int a, input int b,
                                         input logic [7:0] prev);
    logic [7:0] s;
    int r; bit n, v;
    r = expRes(op, a, b);
    s = prev;
    n = (r >= 128);
    case (op)
      0: begin
        s[0] = (a + b) > 255;
        s[5] = ((a % 16) + (b % 16)) > 15;
        v = ((a < 128) == (b < 128)) && ((a < 128) != (r < 128));
      end
      1: begin
        s[0] = b > a;
        s[5] = (b % 16) > (a % 16);
        v = ((a < 128) != (b < 128)) && ((a < 128) != (r < 128));
      end
      2: v = (a == 127);
      default: v = (a == 128);
    endcase
    s[1] = (r == 0);
    s[2] = n;
    s[3] = v;
    s[4] = n ^ v;
    return s;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic loadStat(input logic [7:0] v);
    @(negedge clk);
    opValid = 0; statWrEn = 1; statWrData = v;
    @(negedge clk);
    statWrEn = 0;
  endtask

  // apply one op after seeding status; checks result and status
  task automatic runVec(input int op, input int a, input int b, input logic [7:0] seed);
    logic [7:0] es;
    loadStat(seed);
    opSel = 2'(op); opA = 8'(a); opB = 8'(b); opValid = 1;
    #1;
    case (op)
      0: check($sformatf("R1 add %0d+%0d", a, b), result, expRes(op, a, b));
      1: check($sformatf("R2 sub %0d-%0d", a, b), result, expRes(op, a, b));
      default: check($sformatf("R3 incdec op%0d a=%0d b=%0d", op, a, b), result, expRes(op, a, b));
    endcase
    es = expStat(op, a, b, seed);
    @(negedge clk);
    opValid = 0;
    check($sformatf("R4 R5 R6 R7 R8 R9 R10 status op%0d a=%0d b=%0d", op, a, b), statusOut, es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; opValid = 0; opSel = 0; opA = 0; opB = 0;
    statWrEn = 0; statWrData = 8'hFF;
    // R13: reset clears even with a write pending
    statWrEn = 1;
    repeat (3) @(negedge clk);
    check("R13 reset state", statusOut, 8'h00);
    statWrEn = 0;
    rstN = 1;

    // directed flag examples (R4 R5 R6)
    runVec(0, 8'h9C, 8'h64, 8'h00);
    check("R4 R5 R6 9C+64 flags CHZ", statusOut & 8'h23, 8'h23);
    runVec(0, 8'h38, 8'h2F, 8'h00);
    check("R4 R5 R6 38+2F flags CHZ", statusOut & 8'h23, 8'h20);
    runVec(1, 8'h52, 8'h73, 8'h00);
    check("R4 R5 R6 52-73 flags CHZ", statusOut & 8'h23, 8'h21);
    runVec(1, 8'hA5, 8'h23, 8'h00);
    check("R4 R5 R6 A5-23 flags CHZ", statusOut & 8'h23, 8'h00);
    runVec(1, 8'h9C, 8'h9C, 8'h00);
    check("R6 9C-9C zero", statusOut & 8'h23, 8'h02);
    // R7 overflow boundaries
    runVec(2, 8'h7F, 0, 8'h00);
    check("R7 inc 7F sets V", statusOut & 8'h08, 8'h08);
    runVec(3, 8'h80, 0, 8'h00);
    check("R7 dec 80 sets V", statusOut & 8'h08, 8'h08);
    // R9 carry kept on inc FF
    runVec(2, 8'hFF, 8'h01, 8'h21);
    check("R9 inc FF keeps C H", statusOut & 8'h21, 8'h21);

    // R11 write overrides simultaneous op
    @(negedge clk);
    opSel = 0; opA = 8'h9C; opB = 8'h64; opValid = 1;
    statWrEn = 1; statWrData = 8'h5A;
    @(negedge clk);
    statWrEn = 0; opValid = 0;
    check("R11 write over op", statusOut, 8'h5A);
    // R12 idle holds while operands change
    opA = 8'h00; opB = 8'h00; opSel = 1;
    repeat (3) @(negedge clk);
    check("R12 idle hold", statusOut, 8'h5A);

    // sweep add/sub
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        for (int op = 0; op < 2; op++)
          runVec(op, a, b, 8'((a * 7 + b * 13 + op * 91) % 256));
      end
    end
    // sweep inc/dec with assorted opB (R3 opB ignored)
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        for (int op = 2; op < 4; op++)
          runVec(op, a, (k * 85 + a) % 256, 8'((a * 11 + k * 67 + op * 29) % 256));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule